// File: doc/BRIEF.md
# Reset Cause and Scratch Register Block

This block sits on a small synchronous 16-bit register bus inside a system integration unit. It remembers why the chip last went through a system reset, so that start-up software can tell a cold power-up from a pin-driven reset, a software-requested reset or a watchdog reset. It also offers four general-purpose 16-bit scratch words that keep their contents through every reset except power-on, so software can carry state across a warm restart. Finally, it shows a fixed 32-bit identification code as two read-only 16-bit words.

The power-on reset (`por_n`, active low, sampled on the clock) clears everything and marks a power-on cause. The external reset pin is asynchronous and passes through a two-flop synchronizer. The software and watchdog requests are synchronous. While any of the three warm requests is active, the cause flags are rebuilt from the active requests alone, and bus writes are blocked. Reads take one cycle: the word at `addr` shows on `rd_data` after the clock edge that samples `rd_en`.

Top module: `sysint_rst_regs`

## Requirements
- R1: While `por_n` is low, `rd_data` is 0x0000 and every scratch word clears to zero. Right after `por_n` goes high, the status word at offset 1 reads 0x0004, which is the power-on flag at bit 2 alone.
- R2: The scratch words at offsets 2, 3, 4 and 5 are 16-bit read/write. A read returns data in the cycle after `rd_en`. A read and a write to the same word in the same cycle return the old value.
- R3: A software, watchdog or external-pin reset leaves every scratch word unchanged.
- R4: Each cycle in which a warm request is active (the synchronized pin, `sw_rst_req` or `wdt_rst_req`) rebuilds the status flags. The pin flag is bit 3, the software flag is bit 4 and the watchdog flag is bit 5. Only the flags of the active requests are set, and the power-on flag is cleared. Simultaneous requests set all of their flags.
- R5: The external pin goes through two synchronizer flops. A pin that is high for one clock edge sets bit 3 on the third edge, counting that first edge.
- R6: If the pin is still asserted when `por_n` releases, the status word afterwards reads 0x0008.
- R7: Writing a 1 to a status bit in 5..2 clears that bit, and writing a 0 leaves it unchanged. Bits 1..0 and 15..6 always read zero.
- R8: Offset 6 always reads 0x01F2 and offset 7 always reads 0x401D. Writes to these offsets are ignored.
- R9: Offset 0 and offsets 8..15 read 0x0000, and writes to them change no register.
- R10: Bus writes made while a warm request is active have no effect.
- R11: `rd_data` holds its last value in any cycle where `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| ext_rst_pin | input | 1 | External reset pin, active high, asynchronous |
| sw_rst_req | input | 1 | Software reset request, active high |
| wdt_rst_req | input | 1 | Watchdog reset request, active high |
| addr | input | 4 | Register word offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |

## Verification
The cause capture is driven with several patterns, and each one separates a different fault:
- A single software pulse and a single watchdog pulse show whether each flag lands on its own bit and whether a later cause wipes an earlier one.
- A combined software-and-watchdog pulse shows whether simultaneous causes merge.
- A one-cycle pin pulse, read on every cycle, shows whether the synchronizer depth is right.
- A pin held across power-on release tests the carry-over rule.

Around these, scratch words are written with distinct patterns and read back across each warm reset, and writes are issued during a request, to ID words and to unmapped offsets to confirm that nothing moves. A behavioural model predicts `rd_data` on every cycle.

// File: rtl/sysint_rst_pkg.sv
// Package: shared constants and types for the reset-cause register block.
// Assumes a word-addressed bus; bit positions here are decoded by software.
package sysint_rst_pkg;

    // Status word bit positions
    localparam int POR_BIT = 2;
    localparam int EXT_BIT = 3;
    localparam int SW_BIT  = 4;
    localparam int WDT_BIT = 5;

    // Fixed word offsets; ID words follow the scratch bank
    localparam int OFS_STATUS   = 1;
    localparam int OFS_SCRATCH0 = 2;

    // Cause flags, one bit per reset source
    typedef struct packed {
        logic wdt;
        logic sw;
        logic ext;
        logic por;
    } cause_t;

    // One-hot register select produced by the address decoder
    typedef struct packed {
        logic status;
        logic scratch;
        logic id_hi;
        logic id_lo;
    } hit_t;

endpackage

// File: rtl/sysint_sync.sv
// Module: multi-flop synchronizer for a single asynchronous level.
// Assumes the input is a slow level (reset pin) so no pulse stretching is needed.
module sysint_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/sysint_addr_dec.sv
// Module: decodes a word offset into register selects and a scratch index.
// Assumes the ID words sit right after the last scratch word.
module sysint_addr_dec
    import sysint_rst_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int NUM_SCRATCH = 4,
    parameter int IDX_W       = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output hit_t              hit,
    output logic [IDX_W-1:0]  scratch_idx
);

    localparam int OFS_ID_HI = OFS_SCRATCH0 + NUM_SCRATCH;
    localparam int OFS_ID_LO = OFS_ID_HI + 1;

    // Compare the offset against each mapped range
    always_comb begin
        int a;
        a             = int'(addr);
        hit.status    = (a == OFS_STATUS);
        hit.scratch   = (a >= OFS_SCRATCH0) && (a < OFS_SCRATCH0 + NUM_SCRATCH);
        hit.id_hi     = (a == OFS_ID_HI);
        hit.id_lo     = (a == OFS_ID_LO);
        scratch_idx   = IDX_W'(a - OFS_SCRATCH0);
    end

endmodule

// File: rtl/sysint_cause_reg.sv
// Module: holds the reset-cause flags.
// Power-on sets only the POR flag; any active warm request rebuilds the
// flags from the requests; otherwise software may clear flags by mask.
module sysint_cause_reg
    import sysint_rst_pkg::*;
(
    input  logic   clk,
    input  logic   por_n,
    input  logic   ext_req,
    input  logic   sw_req,
    input  logic   wdt_req,
    input  logic   clr_en,
    input  cause_t clr_mask,
    output cause_t flags,
    output logic   sys_req
);

    assign sys_req = ext_req | sw_req | wdt_req;

    // Update the flags: power-on, then warm reset, then write-one-to-clear
    always_ff @(posedge clk) begin
        if (!por_n) begin
            flags <= '{wdt: 1'b0, sw: 1'b0, ext: 1'b0, por: 1'b1};
        end else if (sys_req) begin
            flags <= '{wdt: wdt_req, sw: sw_req, ext: ext_req, por: 1'b0};
        end else if (clr_en) begin
            flags <= flags & ~clr_mask;
        end
    end

endmodule

// File: rtl/sysint_scratch_bank.sv
// Module: bank of software scratch words cleared only by power-on reset.
// Assumes the caller has already blocked writes during warm resets.
module sysint_scratch_bank #(
    parameter int DATA_W      = 16,
    parameter int NUM_SCRATCH = 4,
    parameter int IDX_W       = 2
) (
    input  logic                          clk,
    input  logic                          por_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [NUM_SCRATCH*DATA_W-1:0] words
);

    for (genvar gi = 0; gi < NUM_SCRATCH; gi++) begin : g_word
        logic [DATA_W-1:0] word_q;

        // Store one scratch word when it is addressed
        always_ff @(posedge clk) begin
            if (!por_n) begin
                word_q <= '0;
            end else if (wr_en && (int'(wr_idx) == gi)) begin
                word_q <= wr_data;
            end
        end

        assign words[gi*DATA_W +: DATA_W] = word_q;
    end

endmodule

// File: rtl/sysint_rd_port.sv
// Module: selects the addressed word and registers it onto the read bus.
// Assumes at most one select in hit is set; no select gives zero.
module sysint_rd_port
    import sysint_rst_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int NUM_SCRATCH = 4,
    parameter int IDX_W       = 2,
    parameter logic [DATA_W-1:0] ID_HI = 'h01F2,
    parameter logic [DATA_W-1:0] ID_LO = 'h401D
) (
    input  logic                          clk,
    input  logic                          por_n,
    input  logic                          rd_en,
    input  hit_t                          hit,
    input  logic [IDX_W-1:0]              scratch_idx,
    input  cause_t                        flags,
    input  logic [NUM_SCRATCH*DATA_W-1:0] words,
    output logic [DATA_W-1:0]             rd_data
);

    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] mux_word;

    // Place the cause flags at their bit positions, all other bits zero
    always_comb begin
        status_word          = '0;
        status_word[POR_BIT] = flags.por;
        status_word[EXT_BIT] = flags.ext;
        status_word[SW_BIT]  = flags.sw;
        status_word[WDT_BIT] = flags.wdt;
    end

    // Pick the addressed word
    always_comb begin
        mux_word = '0;
        if (hit.status) begin
            mux_word = status_word;
        end else if (hit.scratch) begin
            mux_word = words[int'(scratch_idx)*DATA_W +: DATA_W];
        end else if (hit.id_hi) begin
            mux_word = ID_HI;
        end else if (hit.id_lo) begin
            mux_word = ID_LO;
        end
    end

    // Register the read data; hold it when no read is requested
    always_ff @(posedge clk) begin
        if (!por_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= mux_word;
        end
    end

endmodule

// File: rtl/sysint_rst_regs.sv
// Module: top of the reset-cause, scratch and ID register block.
// Assumes a single-cycle synchronous bus; por_n is the only reset of this logic.
module sysint_rst_regs
    import sysint_rst_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 4,
    parameter int NUM_SCRATCH = 4,
    parameter int SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] ID_HI = 'h01F2,
    parameter logic [DATA_W-1:0] ID_LO = 'h401D
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst_pin,
    input  logic              sw_rst_req,
    input  logic              wdt_rst_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int IDX_W = (NUM_SCRATCH > 1) ? $clog2(NUM_SCRATCH) : 1;

    logic                          ext_sync;
    logic                          sys_req;
    logic                          wr_ok;
    hit_t                          hit;
    logic [IDX_W-1:0]              scratch_idx;
    cause_t                        flags;
    cause_t                        clr_mask;
    logic [NUM_SCRATCH*DATA_W-1:0] scratch_words;

    sysint_sync #(
        .STAGES (SYNC_STAGES)
    ) u_pin_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     (ext_rst_pin),
        .q     (ext_sync)
    );

    sysint_addr_dec #(
        .ADDR_W      (ADDR_W),
        .NUM_SCRATCH (NUM_SCRATCH),
        .IDX_W       (IDX_W)
    ) u_dec (
        .addr        (addr),
        .hit         (hit),
        .scratch_idx (scratch_idx)
    );

    // Writes are accepted only outside a warm reset
    assign wr_ok = wr_en && !sys_req;

    // Map write data bits onto the flag clear mask
    always_comb begin
        clr_mask.por = wr_data[POR_BIT];
        clr_mask.ext = wr_data[EXT_BIT];
        clr_mask.sw  = wr_data[SW_BIT];
        clr_mask.wdt = wr_data[WDT_BIT];
    end

    sysint_cause_reg u_cause (
        .clk      (clk),
        .por_n    (por_n),
        .ext_req  (ext_sync),
        .sw_req   (sw_rst_req),
        .wdt_req  (wdt_rst_req),
        .clr_en   (wr_ok && hit.status),
        .clr_mask (clr_mask),
        .flags    (flags),
        .sys_req  (sys_req)
    );

    sysint_scratch_bank #(
        .DATA_W      (DATA_W),
        .NUM_SCRATCH (NUM_SCRATCH),
        .IDX_W       (IDX_W)
    ) u_scratch (
        .clk     (clk),
        .por_n   (por_n),
        .wr_en   (wr_ok && hit.scratch),
        .wr_idx  (scratch_idx),
        .wr_data (wr_data),
        .words   (scratch_words)
    );

    sysint_rd_port #(
        .DATA_W      (DATA_W),
        .NUM_SCRATCH (NUM_SCRATCH),
        .IDX_W       (IDX_W),
        .ID_HI       (ID_HI),
        .ID_LO       (ID_LO)
    ) u_rd (
        .clk         (clk),
        .por_n       (por_n),
        .rd_en       (rd_en),
        .hit         (hit),
        .scratch_idx (scratch_idx),
        .flags       (flags),
        .words       (scratch_words),
        .rd_data     (rd_data)
    );

endmodule

// File: rtl/sysint_rst_regs_chk.sv
// Module: property checker bound into sysint_rst_regs.
// Observes bus ports plus the synchronized pin, warm request, flags and scratch bank.
module sysint_rst_regs_chk #(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 4,
    parameter int NUM_SCRATCH = 4,
    parameter logic [DATA_W-1:0] ID_HI = 'h01F2,
    parameter logic [DATA_W-1:0] ID_LO = 'h401D
) (
    input logic                          clk,
    input logic                          por_n,
    input logic                          rd_en,
    input logic [ADDR_W-1:0]             addr,
    input logic [DATA_W-1:0]             rd_data,
    input logic                          sys_req,
    input logic                          ext_sync,
    input logic                          sw_rst_req,
    input logic                          wdt_rst_req,
    input logic [3:0]                    flags,
    input logic [NUM_SCRATCH*DATA_W-1:0] scratch_words
);

    localparam int OFS_ID_HI = 2 + NUM_SCRATCH;
    localparam int OFS_ID_LO = OFS_ID_HI + 1;

    logic unmapped;
    assign unmapped = (int'(addr) == 0) || (int'(addr) > OFS_ID_LO);

    AST_POR_ONLY_FLAG: assert property (@(posedge clk) disable iff (!por_n)
        $rose(por_n) |-> (flags == 4'b0001)); // R1

    AST_CAUSE_REBUILD: assert property (@(posedge clk) disable iff (!por_n)
        sys_req |=> (flags == {$past(wdt_rst_req), $past(sw_rst_req), $past(ext_sync), 1'b0})); // R4

    AST_SCRATCH_KEPT: assert property (@(posedge clk) disable iff (!por_n)
        sys_req |=> $stable(scratch_words)); // R10

    AST_ID_HI_READ: assert property (@(posedge clk) disable iff (!por_n)
        (rd_en && int'(addr) == OFS_ID_HI) |=> (rd_data == ID_HI)); // R8

    AST_ID_LO_READ: assert property (@(posedge clk) disable iff (!por_n)
        (rd_en && int'(addr) == OFS_ID_LO) |=> (rd_data == ID_LO)); // R8

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        (rd_en && unmapped) |=> (rd_data == '0)); // R9

    AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        (rd_en && int'(addr) == 1) |=> (rd_data[1:0] == 2'b00)); // R7

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        !rd_en |=> $stable(rd_data)); // R11

endmodule

bind sysint_rst_regs sysint_rst_regs_chk #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .NUM_SCRATCH (NUM_SCRATCH),
    .ID_HI       (ID_HI),
    .ID_LO       (ID_LO)
) u_chk (
    .clk           (clk),
    .por_n         (por_n),
    .rd_en         (rd_en),
    .addr          (addr),
    .rd_data       (rd_data),
    .sys_req       (sys_req),
    .ext_sync      (ext_sync),
    .sw_rst_req    (sw_rst_req),
    .wdt_rst_req   (wdt_rst_req),
    .flags         (flags),
    .scratch_words (scratch_words)
);

// File: tb/sysint_rst_regs_tb.sv
module sysint_rst_regs_tb;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        ext_rst_pin = 1'b0;
    logic        sw_rst_req = 1'b0;
    logic        wdt_rst_req = 1'b0;
    logic [3:0]  addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;

    int    checks = 0;
    int    failures = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Behavioural model state
    int m_s1 = 0, m_s2 = 0, m_flags = 1, m_rd = 0;
    int m_scr[4] = '{0, 0, 0, 0};
    bit m_live = 1'b0;

    always #10 clk = ~clk;

    sysint_rst_regs u_dut (
        .clk         (clk),
        .por_n       (por_n),
        .ext_rst_pin (ext_rst_pin),
        .sw_rst_req  (sw_rst_req),
        .wdt_rst_req (wdt_rst_req),
        .addr        (addr),
        .rd_en       (rd_en),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data)
    );

    function automatic int m_read(int a);
        if (a == 1) return (m_flags & 15) << 2;
        if (a >= 2 && a <= 5) return m_scr[a-2];
        if (a == 6) return 'h01F2;
        if (a == 7) return 'h401D;
        return 0;
    endfunction

    // Reference model, advanced on every rising edge
    always @(posedge clk) begin
        int nrd, req, a;
        if (!por_n) begin
            m_s1 = 0; m_s2 = 0; m_flags = 1; m_rd = 0;
            foreach (m_scr[i]) m_scr[i] = 0;
        end else begin
            a   = int'(addr);
            req = m_s2 | int'(sw_rst_req) | int'(wdt_rst_req);
            nrd = rd_en ? m_read(a) : m_rd;
            if (req != 0) begin
                m_flags = (int'(wdt_rst_req) << 3) | (int'(sw_rst_req) << 2) | (m_s2 << 1);
            end else if (wr_en) begin
                if (a == 1) m_flags = m_flags & ~((int'(wr_data) >> 2) & 15);
                else if (a >= 2 && a <= 5) m_scr[a-2] = int'(wr_data);
            end
            m_s2 = m_s1;
            m_s1 = int'(ext_rst_pin);
            m_rd = nrd;
        end
        m_live = 1'b1;
    end

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%04h expected=%04h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (m_live && !done) check(int'(rd_data), m_rd, cur_req);
    end

    task automatic rd_chk(input int a, input int exp, input string tag);
        addr = 4'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(int'(rd_data), exp, tag);
    endtask

    task automatic wr(input int a, input int d);
        addr = 4'(a); wr_data = 16'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            finish_run();
        end
    end

    initial begin
        // R1: power-on state
        cur_req = "R1";
        idle(3);
        check(int'(rd_data), 0, "R1 rd_data in reset");
        por_n = 1'b1;
        rd_chk(1, 'h0004, "R1 status after power-on");
        rd_chk(2, 0, "R1 scratch cleared");

        // R2: scratch read/write
        cur_req = "R2";
        wr(2, 'h1234); wr(3, 'hA5A5); wr(4, 'hFFFF); wr(5, 'h0001);
        rd_chk(2, 'h1234, "R2 scratch0");
        rd_chk(3, 'hA5A5, "R2 scratch1");
        rd_chk(4, 'hFFFF, "R2 scratch2");
        rd_chk(5, 'h0001, "R2 scratch3");
        addr = 4'd2; wr_data = 16'h5555; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check(int'(rd_data), 'h1234, "R2 read-during-write old value");
        rd_chk(2, 'h5555, "R2 new value");

        // R11: read data holds without rd_en
        cur_req = "R11";
        addr = 4'd3;
        idle(3);
        check(int'(rd_data), 'h5555, "R11 hold");

        // R8: ID words
        cur_req = "R8";
        rd_chk(6, 'h01F2, "R8 id hi");
        rd_chk(7, 'h401D, "R8 id lo");
        wr(6, 'h0000); wr(7, 'hFFFF);
        rd_chk(6, 'h01F2, "R8 id hi after write");
        rd_chk(7, 'h401D, "R8 id lo after write");

        // R9: unmapped offsets
        cur_req = "R9";
        rd_chk(0, 0, "R9 offset 0");
        rd_chk(8, 0, "R9 offset 8");
        wr(0, 'hBEEF); wr(9, 'hBEEF); wr(15, 'hBEEF);
        rd_chk(15, 0, "R9 offset 15");
        rd_chk(2, 'h5555, "R9 scratch untouched");
        rd_chk(1, 'h0004, "R9 status untouched");

        // R7: write-one-to-clear status
        cur_req = "R7";
        wr(1, 'hFFC3);
        rd_chk(1, 'h0004, "R7 zeros and reserved bits do not clear");
        wr(1, 'h0004);
        rd_chk(1, 'h0000, "R7 clear por flag");

        // R4 / R3: warm reset causes
        cur_req = "R4";
        sw_rst_req = 1'b1; @(negedge clk); sw_rst_req = 1'b0;
        rd_chk(1, 'h0010, "R4 software cause");
        wdt_rst_req = 1'b1; @(negedge clk); wdt_rst_req = 1'b0;
        rd_chk(1, 'h0020, "R4 watchdog cause replaces software");
        sw_rst_req = 1'b1; wdt_rst_req = 1'b1; @(negedge clk);
        sw_rst_req = 1'b0; wdt_rst_req = 1'b0;
        rd_chk(1, 'h0030, "R4 both causes");
        cur_req = "R3";
        rd_chk(2, 'h5555, "R3 scratch0 kept");
        rd_chk(3, 'hA5A5, "R3 scratch1 kept");
        cur_req = "R7";
        wr(1, 'h0020);
        rd_chk(1, 'h0010, "R7 partial clear");
        wr(1, 'h003C);
        rd_chk(1, 'h0000, "R7 clear all");

        // R5: pin synchronizer latency, continuous reads of status
        cur_req = "R5";
        addr = 4'd1; rd_en = 1'b1; ext_rst_pin = 1'b1;
        @(negedge clk); ext_rst_pin = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(int'(rd_data), 'h0000, "R5 flag not yet set at third edge read");
        @(negedge clk);
        check(int'(rd_data), 'h0008, "R5 flag visible after third edge");
        rd_en = 1'b0;
        idle(3);
        cur_req = "R3";
        rd_chk(4, 'hFFFF, "R3 scratch kept after pin reset");

        // R10: writes during a warm request are dropped
        cur_req = "R10";
        sw_rst_req = 1'b1;
        wr(2, 'hDEAD);
        wr(1, 'h003C);
        sw_rst_req = 1'b0;
        rd_chk(2, 'h5555, "R10 scratch write blocked");
        rd_chk(1, 'h0010, "R10 status clear blocked");

        // R6: pin held across power-on release
        cur_req = "R6";
        por_n = 1'b0; ext_rst_pin = 1'b1;
        idle(3);
        check(int'(rd_data), 0, "R1 rd_data in second reset");
        por_n = 1'b1;
        idle(4);
        ext_rst_pin = 1'b0;
        idle(4);
        rd_chk(1, 'h0008, "R6 pin flag after power-on");
        rd_chk(2, 0, "R6 scratch cleared by power-on");

        idle(2);
        finish_run();
    end

endmodule